// File: doc/BRIEF.md
# Three-Stage Pipeline Hazard and Redirect Controller

This block sequences a single-issue, in-order 32-bit integer pipeline whose stages are a combined fetch/decode stage, an execute stage and a write-back stage. It owns the fetch address register and the valid bit of every stage. It also keeps the destination index and write enable of the two older instructions in flight. The datapath reads register operands in fetch/decode. The controller compares the two source indices of that instruction against the older destinations and drives the select lines of the operand bypass multiplexers. A read-after-write dependency therefore never costs a stall.

Branches and jumps resolve in execute. When execute reports a taken branch, or when a trap or interrupt asks for a redirect, the controller raises `flush`. The instruction already in fetch/decode and the fetch still in flight are both cancelled, and the fetch address loads the new target on the next edge. The penalty is a fixed two cycles. Memories always accept a request, so the controller has no wait or stall input, and every other instruction advances at one per cycle.

Top module: `hz_pipe_ctrl`

## Requirements
- R1: While `rst` is high on a clock edge, `fd_valid`, `ex_valid` and `wb_valid` clear and `fetch_pc` loads the parameter `RESET_VEC`.
- R2: On an edge with `flush` low, `fetch_pc` advances by 4. After the first edge following reset, `fd_valid` is high in every cycle that does not follow a flush, and `ex_valid` equals the previous cycle's `fd_valid`.
- R3: A source select reads 1 (execute result) when its index is nonzero and equals `ex_rd` of a valid, writing execute-stage instruction.
- R4: A source select reads 2 (write-back result) when its index is nonzero, the execute stage does not match, and the index equals `wb_rd` of a valid, writing write-back instruction.
- R5: When both the execute and the write-back destinations match a nonzero source, the select reads 1: the younger result wins.
- R6: A source index of 0 always gives select 0 (register file), whatever the older destinations are.
- R7: A destination in a stage that is invalid, or that does not write, never gives a bypass. With no valid match the select is 0.
- R8: `br_taken` while `ex_valid` is high raises `flush` in the same cycle. On the next edge `fetch_pc` loads `br_target`, and both `fd_valid` and `ex_valid` go low for that following cycle.
- R9: `br_taken` while `ex_valid` is low has no effect: `flush` stays low and `fetch_pc` advances by 4.
- R10: `trap_req` raises `flush` whatever `ex_valid` is, and `fetch_pc` loads `trap_vec`. When a trap and a taken branch arrive together, the trap target wins.
- R11: The instruction in execute is never cancelled by a flush: `wb_valid` always equals the previous cycle's `ex_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_rs1 | input | RW | First source index of the decode instruction |
| dec_rs2 | input | RW | Second source index of the decode instruction |
| dec_rd | input | RW | Destination index of the decode instruction |
| dec_wen | input | 1 | Decode instruction writes a register |
| br_taken | input | 1 | Execute reports a taken branch or jump |
| br_target | input | PC_W | Branch or jump target address |
| trap_req | input | 1 | Trap or interrupt redirect request |
| trap_vec | input | PC_W | Trap handler address |
| fetch_pc | output | PC_W | Address presented to instruction memory |
| flush | output | 1 | Cancel the two younger instructions this cycle |
| fd_valid | output | 1 | Fetch/decode stage holds a live instruction |
| ex_valid | output | 1 | Execute stage holds a live instruction |
| wb_valid | output | 1 | Write-back stage holds a live instruction |
| fwd_rs1_sel | output | 2 | Operand 1 source: 0 register file, 1 execute, 2 write-back |
| fwd_rs2_sel | output | 2 | Operand 2 source: 0 register file, 1 execute, 2 write-back |

## Verification
The bench uses a small index range so that both older stages often hit the same source register. This exercises the priority case, where a design that preferred write-back would hand the datapath a stale value. Index 0 shows up often alongside matching destinations, so a design that bypassed into x0 would return a nonzero zero-register. Taken branches are placed in the bubble cycles that follow a flush, where a design that ignored the execute valid bit would redirect on a dead branch. Traps collide with branches, so a design that got the priority wrong would land at the branch target. Every flush is followed through the valid bits, which catches a design that kills one bubble instead of two, or one that also cancels the branch itself.

// File: rtl/hz_pipe_pkg.sv
package hz_pipe_pkg;
  // Operand source encoding driven onto the bypass multiplexers
  typedef enum logic [1:0] {
    SRC_RF = 2'd0,
    SRC_EX = 2'd1,
    SRC_WB = 2'd2
  } opnd_src_e;

  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/hz_stage_track.sv
// Tracks liveness and destination of the three pipeline stages.
module hz_stage_track #(
  parameter int unsigned RW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [RW-1:0] dec_rd,
  input  logic          dec_wen,
  output logic          fd_valid,
  output logic          ex_valid,
  output logic          ex_wen,
  output logic [RW-1:0] ex_rd,
  output logic          wb_valid,
  output logic          wb_wen,
  output logic [RW-1:0] wb_rd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fd_valid <= 1'b0;
      ex_valid <= 1'b0;
      ex_wen   <= 1'b0;
      ex_rd    <= '0;
      wb_valid <= 1'b0;
      wb_wen   <= 1'b0;
      wb_rd    <= '0;
    end else begin
      // the fetch in flight lands in decode unless cancelled
      fd_valid <= ~flush;
      // the decode instruction is cancelled by a flush
      ex_valid <= fd_valid & ~flush;
      ex_wen   <= dec_wen;
      ex_rd    <= dec_rd;
      // the redirecting instruction itself always retires
      wb_valid <= ex_valid;
      wb_wen   <= ex_wen;
      wb_rd    <= ex_rd;
    end
  end
endmodule

// File: rtl/hz_pc_ctrl.sv
// Fetch address register with redirect arbitration.
module hz_pc_ctrl #(
  parameter int unsigned     PC_W      = 32,
  parameter logic [PC_W-1:0] RESET_VEC = '0,
  parameter int unsigned     STEP      = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ex_valid,
  input  logic            br_taken,
  input  logic [PC_W-1:0] br_target,
  input  logic            trap_req,
  input  logic [PC_W-1:0] trap_vec,
  output logic [PC_W-1:0] fetch_pc,
  output logic            flush
);
  localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

  logic            br_live;
  logic [PC_W-1:0] redir_pc;

  always_comb begin
    br_live  = br_taken & ex_valid;
    flush    = br_live | trap_req;
    redir_pc = trap_req ? trap_vec : br_target;
  end

  always_ff @(posedge clk) begin
    if (rst)        fetch_pc <= RESET_VEC;
    else if (flush) fetch_pc <= redir_pc;
    else            fetch_pc <= fetch_pc + STEP_V;
  end
endmodule

// File: rtl/hz_fwd_unit.sv
// Bypass select for one source operand.
module hz_fwd_unit
  import hz_pipe_pkg::*;
#(
  parameter int unsigned RW = 5
) (
  input  logic          [RW-1:0] rs,
  input  logic                   ex_valid,
  input  logic                   ex_wen,
  input  logic          [RW-1:0] ex_rd,
  input  logic                   wb_valid,
  input  logic                   wb_wen,
  input  logic          [RW-1:0] wb_rd,
  output opnd_src_e              sel
);
  logic rs_nz, hit_ex, hit_wb;

  always_comb begin
    rs_nz  = |rs;
    hit_ex = rs_nz & ex_valid & ex_wen & (ex_rd == rs);
    hit_wb = rs_nz & wb_valid & wb_wen & (wb_rd == rs);
    if (hit_ex)      sel = SRC_EX;
    else if (hit_wb) sel = SRC_WB;
    else             sel = SRC_RF;
  end
endmodule

// File: rtl/hz_pipe_ctrl.sv
module hz_pipe_ctrl
  import hz_pipe_pkg::*;
#(
  parameter int unsigned     RW        = 5,
  parameter int unsigned     PC_W      = 32,
  parameter logic [PC_W-1:0] RESET_VEC = 32'h0000_0000,
  parameter int unsigned     STEP      = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RW-1:0]   dec_rs1,
  input  logic [RW-1:0]   dec_rs2,
  input  logic [RW-1:0]   dec_rd,
  input  logic            dec_wen,
  input  logic            br_taken,
  input  logic [PC_W-1:0] br_target,
  input  logic            trap_req,
  input  logic [PC_W-1:0] trap_vec,
  output logic [PC_W-1:0] fetch_pc,
  output logic            flush,
  output logic            fd_valid,
  output logic            ex_valid,
  output logic            wb_valid,
  output logic [1:0]      fwd_rs1_sel,
  output logic [1:0]      fwd_rs2_sel
);
  logic          ex_wen, wb_wen;
  logic [RW-1:0] ex_rd, wb_rd;
  logic [RW-1:0] src_idx [NUM_SRC];
  opnd_src_e     src_sel [NUM_SRC];

  hz_stage_track #(.RW(RW)) u_track (
    .clk(clk), .rst(rst), .flush(flush),
    .dec_rd(dec_rd), .dec_wen(dec_wen),
    .fd_valid(fd_valid), .ex_valid(ex_valid), .ex_wen(ex_wen), .ex_rd(ex_rd),
    .wb_valid(wb_valid), .wb_wen(wb_wen), .wb_rd(wb_rd)
  );

  hz_pc_ctrl #(.PC_W(PC_W), .RESET_VEC(RESET_VEC), .STEP(STEP)) u_pc (
    .clk(clk), .rst(rst), .ex_valid(ex_valid),
    .br_taken(br_taken), .br_target(br_target),
    .trap_req(trap_req), .trap_vec(trap_vec),
    .fetch_pc(fetch_pc), .flush(flush)
  );

  assign src_idx[0] = dec_rs1;
  assign src_idx[1] = dec_rs2;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    hz_fwd_unit #(.RW(RW)) u_fwd (
      .rs(src_idx[g]),
      .ex_valid(ex_valid), .ex_wen(ex_wen), .ex_rd(ex_rd),
      .wb_valid(wb_valid), .wb_wen(wb_wen), .wb_rd(wb_rd),
      .sel(src_sel[g])
    );
  end

  assign fwd_rs1_sel = src_sel[0];
  assign fwd_rs2_sel = src_sel[1];
endmodule

// File: rtl/hz_pipe_ctrl_chk.sv
module hz_pipe_ctrl_chk #(
  parameter int unsigned RW   = 5,
  parameter int unsigned PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [RW-1:0]   dec_rs1,
  input logic [RW-1:0]   dec_rs2,
  input logic            br_taken,
  input logic            trap_req,
  input logic [PC_W-1:0] trap_vec,
  input logic [PC_W-1:0] fetch_pc,
  input logic            flush,
  input logic            fd_valid,
  input logic            ex_valid,
  input logic            wb_valid,
  input logic [1:0]      fwd_rs1_sel,
  input logic [1:0]      fwd_rs2_sel
);
  p_seq_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    !flush |=> fetch_pc == $past(fetch_pc) + PC_W'(4));

  p_zero_src_rs1_r6: assert property (@(posedge clk) disable iff (rst)
    (dec_rs1 == '0) |-> (fwd_rs1_sel == 2'd0));

  p_zero_src_rs2_r6: assert property (@(posedge clk) disable iff (rst)
    (dec_rs2 == '0) |-> (fwd_rs2_sel == 2'd0));

  p_flush_kills_two_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!fd_valid && !ex_valid));

  p_dead_branch_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (br_taken && !ex_valid && !trap_req) |-> !flush);

  p_trap_target_r10: assert property (@(posedge clk) disable iff (rst)
    trap_req |=> fetch_pc == $past(trap_vec));

  p_wb_follows_ex_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> wb_valid == $past(ex_valid));
endmodule

bind hz_pipe_ctrl hz_pipe_ctrl_chk #(.RW(RW), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .dec_rs1(dec_rs1), .dec_rs2(dec_rs2),
  .br_taken(br_taken), .trap_req(trap_req), .trap_vec(trap_vec),
  .fetch_pc(fetch_pc), .flush(flush), .fd_valid(fd_valid),
  .ex_valid(ex_valid), .wb_valid(wb_valid),
  .fwd_rs1_sel(fwd_rs1_sel), .fwd_rs2_sel(fwd_rs2_sel)
);

// File: tb/tb_hz_pipe_ctrl.sv
module tb_hz_pipe_ctrl;
  localparam int CLK_P = 10;
  localparam int RW = 5;
  localparam int PC_W = 32;
  localparam logic [31:0] RVEC = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [RW-1:0] dec_rs1 = '0, dec_rs2 = '0, dec_rd = '0;
  logic dec_wen = 1'b0, br_taken = 1'b0, trap_req = 1'b0;
  logic [PC_W-1:0] br_target = '0, trap_vec = '0;
  logic [PC_W-1:0] fetch_pc;
  logic flush, fd_valid, ex_valid, wb_valid;
  logic [1:0] fwd_rs1_sel, fwd_rs2_sel;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  // behavioural model state (after the most recent edge)
  int m_pc;
  bit m_fdv, m_exv, m_wbv, m_exw, m_wbw;
  int m_exrd, m_wbrd;

  always #(CLK_P/2) clk = ~clk;

  hz_pipe_ctrl #(.RW(RW), .PC_W(PC_W), .RESET_VEC(RVEC)) dut (
    .clk(clk), .rst(rst), .dec_rs1(dec_rs1), .dec_rs2(dec_rs2),
    .dec_rd(dec_rd), .dec_wen(dec_wen), .br_taken(br_taken),
    .br_target(br_target), .trap_req(trap_req), .trap_vec(trap_vec),
    .fetch_pc(fetch_pc), .flush(flush), .fd_valid(fd_valid),
    .ex_valid(ex_valid), .wb_valid(wb_valid),
    .fwd_rs1_sel(fwd_rs1_sel), .fwd_rs2_sel(fwd_rs2_sel)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // expected select per requirement: 0 RF, 1 execute, 2 write-back
  function automatic int exp_sel(int rs, output string tag);
    bit ex_hit = m_exv && m_exw && m_exrd == rs;
    bit wb_hit = m_wbv && m_wbw && m_wbrd == rs;
    if (rs == 0) begin tag = "R6"; return 0; end
    if (ex_hit) begin tag = wb_hit ? "R5" : "R3"; return 1; end
    if (wb_hit) begin tag = "R4"; return 2; end
    tag = "R7";
    return 0;
  endfunction

  // one cycle: drive inputs, check at negedge, advance model at the edge
  task automatic step(int rs1, int rs2, int rd, bit wen, bit br, int tgt, bit trp, int tv);
    string t1, t2, ptag;
    int e1, e2;
    bit exp_fl;
    bit live_br;
    dec_rs1 = RW'(rs1); dec_rs2 = RW'(rs2); dec_rd = RW'(rd); dec_wen = wen;
    br_taken = br; br_target = PC_W'(tgt); trap_req = trp; trap_vec = PC_W'(tv);
    @(negedge clk);
    e1 = exp_sel(rs1, t1);
    e2 = exp_sel(rs2, t2);
    chk(t1, "fwd_rs1_sel", fwd_rs1_sel, e1);
    chk(t2, "fwd_rs2_sel", fwd_rs2_sel, e2);
    live_br = br && m_exv;
    exp_fl = live_br || trp;
    ptag = trp ? "R10" : (live_br ? "R8" : (br ? "R9" : "R2"));
    chk(ptag, "flush", flush, exp_fl);
    chk("R2", "fetch_pc", fetch_pc, m_pc);
    chk("R2", "fd_valid", fd_valid, m_fdv);
    chk("R8", "ex_valid", ex_valid, m_exv);
    chk("R11", "wb_valid", wb_valid, m_wbv);
    @(posedge clk);
    m_wbv = m_exv; m_wbw = m_exw; m_wbrd = m_exrd;
    m_exv = m_fdv && !exp_fl; m_exw = wen; m_exrd = rd;
    m_fdv = !exp_fl;
    m_pc = trp ? tv : (live_br ? tgt : m_pc + 4);
    #1;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "fd_valid", fd_valid, 0);
    chk("R1", "ex_valid", ex_valid, 0);
    chk("R1", "wb_valid", wb_valid, 0);
    chk("R1", "fetch_pc", fetch_pc, RVEC);
    rst = 1'b0;
    m_pc = RVEC; m_fdv = 0; m_exv = 0; m_wbv = 0;
    m_exw = 0; m_wbw = 0; m_exrd = 0; m_wbrd = 0;

    // warm-up sequential fetch (R2)
    step(0, 0, 3, 1, 0, 0, 0, 0);
    step(0, 0, 5, 1, 0, 0, 0, 0);
    // R3/R4/R5: x3 then x5 in flight, then both write x7
    step(5, 3, 7, 1, 0, 0, 0, 0);
    step(7, 0, 7, 1, 0, 0, 0, 0);
    step(7, 5, 2, 0, 0, 0, 0, 0);
    // R6: x0 destination in flight, source 0
    step(0, 0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    // R7: non-writing destination not bypassed
    step(2, 0, 9, 0, 0, 0, 0, 0);
    step(9, 2, 1, 1, 0, 0, 0, 0);
    // R8: taken branch, then R9: branch in the bubbles
    step(1, 1, 4, 1, 1, 32'h0000_2000, 0, 0);
    step(4, 1, 6, 1, 1, 32'h0000_3000, 0, 0);
    step(6, 4, 6, 1, 1, 32'h0000_3000, 0, 0);
    step(6, 0, 0, 0, 0, 0, 0, 0);
    step(6, 0, 0, 0, 0, 0, 0, 0);
    // R10: trap together with a taken branch
    step(0, 0, 8, 1, 1, 32'h0000_4000, 1, 32'h0000_0800);
    step(8, 0, 0, 0, 0, 0, 0, 0);
    step(8, 0, 0, 0, 0, 0, 0, 0);
    // R10: trap with execute empty
    step(0, 0, 0, 0, 0, 0, 1, 32'h0000_0900);
    step(0, 0, 0, 0, 0, 0, 0, 0);

    // mixed traffic over a narrow register range
    for (int i = 0; i < 4000; i++) begin
      int r1 = $urandom % 4;
      int r2 = $urandom % 4;
      int rd = $urandom % 4;
      bit w = ($urandom % 4) != 0;
      bit b = ($urandom % 6) == 0;
      bit tr = ($urandom % 40) == 0;
      int tg = ($urandom % 65536) << 2;
      int tv = ($urandom % 1024) << 2;
      step(r1, r2, rd, w, b, tg, tr, tv);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule